// File: doc/BRIEF.md
# Pipelined Bit-Serial Rank Selector

This block picks, from a window of M unsigned N-bit words, the word that holds a requested rank. Instead of a comparator network it settles the answer one bit-plane at a time, beginning at the most significant plane. Each plane casts a threshold vote over the M bits of that plane, with the threshold set by the rank. Every word whose bit disagrees with the vote is frozen: its disagreeing bit then stands in for all of its lower bits. Words that match the vote continue unchanged to the next plane.

There is one pipeline stage per bit-plane. Each stage carries the lower raw bits, which act as the input skew, and the result bits decided so far, which act as the output deskew. The rank travels with its window, so at any moment every stage can be working on a different rank. A window and its rank enter through a valid/ready handshake, and the selected word leaves through a second one. A transfer takes place on a clock edge where valid and ready are both high. The whole pipeline advances together: it moves whenever the output register is empty or is being drained. Any stall at the output therefore holds every stage and deasserts `in_ready` in the same cycle.

Rank 1 selects the largest word and rank M selects the smallest. Rank (M+1)/2 yields the median.

Top module: `rank_select_top`

## Requirements
- R1: After reset `out_valid` is 0 and `in_ready` is 1.
- R2: For a window accepted with rank r in 1..M, the delivered word equals the element at position r of the window sorted from largest to smallest, duplicates included. Words are packed with word w at bits [w*N +: N].
- R3: Rank 1 delivers the maximum of the window and rank M delivers the minimum.
- R4: A rank of 0 is treated as 1, and a rank above M (6 or 7 with the default M=5 and 3-bit rank) is treated as M.
- R5: Windows accepted on consecutive edges with different ranks each receive the result for their own rank.
- R6: A window accepted on clock edge k appears with `out_valid` high right after edge k+N-1, provided no stall occurs. It is not valid after edge k+N-2.
- R7: With `out_ready` held at 1 and a new window offered every cycle, `in_ready` stays 1 and, once the pipeline is full, one result is delivered every cycle.
- R8: While `out_valid` is 1 and `out_ready` is 0, `out_word` and `out_valid` hold their values into the next cycle. No window is lost or repeated.
- R9: `in_ready` equals `!out_valid || out_ready` in every cycle.
- R10: With rank (M+1)/2 the delivered word is the median of the window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Window and rank are offered |
| in_ready | output | 1 | Pipeline can take a window this cycle |
| in_words | input | M*N | Window words, word w at [w*N +: N] |
| in_rank | input | $clog2(M+1) | Requested rank, 1 = largest |
| out_valid | output | 1 | Selected word is present |
| out_ready | input | 1 | Consumer takes the word this cycle |
| out_word | output | N | Selected word |

## Verification
Two things can happen in the same cycle: an output stall can arrive while the stages inside the pipeline each hold a window with a different rank. The bench provokes this by changing the rank on every accepted window and toggling `out_ready` and `in_valid` pseudo-randomly. The stall freezes every plane and its rank at once. A scoreboard queue of arithmetically sorted expectations checks each delivered word in order, and a stalled word is compared with its value in the previous cycle.

// File: rtl/rank_select_pkg.sv
package rank_select_pkg;

  // Map any requested rank onto the legal range 1..m.
  function automatic int clamp_rank(input int r, input int m);
    if (r < 1) return 1;
    if (r > m) return m;
    return r;
  endfunction

endpackage

// File: rtl/rank_vote.sv
module rank_vote #(
  parameter int unsigned M  = 5,
  parameter int unsigned RW = $clog2(M + 1)
) (
  input  logic [M-1:0]  bits,
  input  logic [RW-1:0] thresh,
  output logic          hit
);
  logic [RW-1:0] ones;

  always_comb begin
    ones = '0;
    for (int w = 0; w < int'(M); w++) ones = ones + RW'(bits[w]);
  end

  assign hit = (ones >= thresh);
endmodule

// File: rtl/rank_plane.sv
module rank_plane #(
  parameter int unsigned M     = 5,
  parameter int unsigned N     = 8,
  parameter int unsigned RW    = $clog2(M + 1),
  parameter int unsigned PLANE = N - 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            adv,
  input  logic            vld_i,
  input  logic [RW-1:0]   rank_i,
  input  logic [M*N-1:0]  raw_i,
  input  logic [M-1:0]    lock_i,
  input  logic [M-1:0]    lval_i,
  input  logic [N-1:0]    res_i,
  output logic            vld_o,
  output logic [RW-1:0]   rank_o,
  output logic [M*N-1:0]  raw_o,
  output logic [M-1:0]    lock_o,
  output logic [M-1:0]    lval_o,
  output logic [N-1:0]    res_o
);
  logic [M-1:0] eff, lock_n, lval_n;
  logic [N-1:0] res_n;
  logic         dec;

  always_comb begin
    for (int w = 0; w < int'(M); w++)
      eff[w] = lock_i[w] ? lval_i[w] : raw_i[w*N + int'(PLANE)];
  end

  rank_vote #(.M(M), .RW(RW)) i_vote (.bits(eff), .thresh(rank_i), .hit(dec));

  always_comb begin
    for (int w = 0; w < int'(M); w++) begin
      lock_n[w] = lock_i[w] | (eff[w] != dec);
      lval_n[w] = lock_i[w] ? lval_i[w] : eff[w];
    end
    res_n        = res_i;
    res_n[PLANE] = dec;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_o  <= 1'b0;
      rank_o <= '0;
      raw_o  <= '0;
      lock_o <= '0;
      lval_o <= '0;
      res_o  <= '0;
    end else if (adv) begin
      vld_o  <= vld_i;
      rank_o <= rank_i;
      raw_o  <= raw_i;
      lock_o <= lock_n;
      lval_o <= lval_n;
      res_o  <= res_n;
    end
  end

  // R4: only legal ranks reach a vote
  a_r4_rank_legal: assert property (@(posedge clk) disable iff (!rst_n)
    vld_i |-> (rank_i >= RW'(1) && rank_i <= RW'(M)));

  // R2: a frozen word never thaws on its way down
  a_r2_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && vld_i) |=> ((lock_o & $past(lock_i)) == $past(lock_i)));

  // R8: a stall holds every stage
  a_r8_stage_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> ($stable(vld_o) && $stable(res_o) && $stable(rank_o)));
endmodule

// File: rtl/rank_select_top.sv
module rank_select_top #(
  parameter int unsigned M  = 5,
  parameter int unsigned N  = 8,
  parameter int unsigned RW = $clog2(M + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [M*N-1:0] in_words,
  input  logic [RW-1:0]  in_rank,
  output logic           out_valid,
  input  logic           out_ready,
  output logic [N-1:0]   out_word
);
  logic           vld_c  [N+1];
  logic [RW-1:0]  rank_c [N+1];
  logic [M*N-1:0] raw_c  [N+1];
  logic [M-1:0]   lock_c [N+1];
  logic [M-1:0]   lval_c [N+1];
  logic [N-1:0]   res_c  [N+1];
  logic           adv;

  assign adv       = !out_valid || out_ready;
  assign in_ready  = adv;

  assign vld_c[0]  = in_valid;
  assign rank_c[0] = RW'(rank_select_pkg::clamp_rank(int'(in_rank), int'(M)));
  assign raw_c[0]  = in_words;
  assign lock_c[0] = '0;
  assign lval_c[0] = '0;
  assign res_c[0]  = '0;

  for (genvar s = 0; s < int'(N); s++) begin : g_plane
    rank_plane #(.M(M), .N(N), .RW(RW), .PLANE(N - 1 - s)) i_plane (
      .clk   (clk),
      .rst_n (rst_n),
      .adv   (adv),
      .vld_i (vld_c[s]),
      .rank_i(rank_c[s]),
      .raw_i (raw_c[s]),
      .lock_i(lock_c[s]),
      .lval_i(lval_c[s]),
      .res_i (res_c[s]),
      .vld_o (vld_c[s+1]),
      .rank_o(rank_c[s+1]),
      .raw_o (raw_c[s+1]),
      .lock_o(lock_c[s+1]),
      .lval_o(lval_c[s+1]),
      .res_o (res_c[s+1])
    );
  end

  assign out_valid = vld_c[N];
  assign out_word  = res_c[N];

  // Survivors (never frozen) must all equal the chosen word, and one must exist.
  logic surv_ok;
  always_comb begin
    logic any, bad;
    any = 1'b0;
    bad = 1'b0;
    for (int w = 0; w < int'(M); w++) begin
      if (!lock_c[N][w]) begin
        any = 1'b1;
        if (raw_c[N][w*N +: N] != out_word) bad = 1'b1;
      end
    end
    surv_ok = any && !bad;
  end

  // R8: a stalled result holds
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_word)));

  // R2: the result is one of the window's words
  a_r2_survivor: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> surv_ok);

  // R2: fewer than r words sit above the result
  a_r2_above: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ($countones(lock_c[N] & lval_c[N]) < int'(rank_c[N])));

  // R2: at most M-r words sit below the result
  a_r2_below: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ($countones(lock_c[N] & ~lval_c[N]) <= int'(M) - int'(rank_c[N])));
endmodule

// File: tb/test_rank_select_top.sv
module test_rank_select_top;
  localparam int M = 5;
  localparam int N = 8;
  localparam int RW = $clog2(M + 1);
  localparam time TCLK = 10ns;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [M*N-1:0] in_words = '0;
  logic [RW-1:0] in_rank = '0;
  logic out_valid;
  logic out_ready = 1'b0;
  logic [N-1:0] out_word;

  int total = 0;
  int bad = 0;
  int exp_q[$];
  string tag_q[$];
  bit prev_stall = 1'b0;
  logic [N-1:0] prev_word = '0;
  int unsigned seed = 32'h1234_5678;
  bit done = 1'b0;

  always #(TCLK/2) clk = ~clk;

  rank_select_top #(.M(M), .N(N)) i_rank_select_top (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_words(in_words), .in_rank(in_rank), .out_valid(out_valid),
    .out_ready(out_ready), .out_word(out_word)
  );

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic int unsigned nxt();
    seed ^= seed << 13;
    seed ^= seed >> 17;
    seed ^= seed << 5;
    return seed;
  endfunction

  function automatic int expect_of(input logic [M*N-1:0] wv, input int r);
    int a[M];
    int rr;
    for (int i = 0; i < M; i++) a[i] = int'(wv[i*N +: N]);
    for (int i = 0; i < M; i++)
      for (int j = 0; j < M - 1 - i; j++)
        if (a[j] < a[j+1]) begin
          int t = a[j]; a[j] = a[j+1]; a[j+1] = t;
        end
    rr = (r < 1) ? 1 : (r > M) ? M : r;
    return a[rr-1];
  endfunction

  function automatic string tag_of(input int r);
    if (r < 1 || r > M) return "R4";
    if (r == (M + 1) / 2) return "R10";
    if (r == 1 || r == M) return "R3";
    return "R2/R5";
  endfunction

  // One cycle: drive at the falling edge, observe, score the coming handshake.
  task automatic step(input bit iv, input bit ordy, input logic [M*N-1:0] wv, input int r);
    @(negedge clk);
    in_valid  = iv;
    out_ready = ordy;
    in_words  = wv;
    in_rank   = RW'(r);
    #1;
    chk(in_ready == (!out_valid || out_ready), "R9", int'(in_ready), int'(!out_valid || out_ready));
    if (prev_stall) begin
      chk(out_valid == 1'b1, "R8", int'(out_valid), 1);
      chk(out_word == prev_word, "R8", int'(out_word), int'(prev_word));
    end
    if (out_valid && out_ready) begin
      if (exp_q.size() == 0) chk(1'b0, "R8", int'(out_word), -1);
      else begin
        int e = exp_q.pop_front();
        string t = tag_q.pop_front();
        chk(int'(out_word) == e, t, int'(out_word), e);
      end
    end
    if (in_valid && in_ready) begin
      exp_q.push_back(expect_of(wv, r));
      tag_q.push_back(tag_of(r));
    end
    prev_stall = out_valid && !out_ready;
    prev_word  = out_word;
  endtask

  function automatic logic [M*N-1:0] make_window(input int kind);
    logic [M*N-1:0] wv;
    for (int i = 0; i < M; i++) begin
      int unsigned v = nxt();
      case (kind % 4)
        0: wv[i*N +: N] = N'(v);
        1: wv[i*N +: N] = N'(v & 3);
        2: wv[i*N +: N] = N'(v) | 8'hF0;
        default: wv[i*N +: N] = (v[0]) ? '1 : '0;
      endcase
    end
    return wv;
  endfunction

  task automatic drain();
    for (int k = 0; k < 4 * N && exp_q.size() != 0; k++) step(1'b0, 1'b1, '0, 1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(out_valid == 1'b0, "R1", int'(out_valid), 0);
    chk(in_ready == 1'b1, "R1", int'(in_ready), 1);

    // R6: latency of a lone window
    begin
      logic [M*N-1:0] wv = make_window(0);
      step(1'b1, 1'b1, wv, 1);
      for (int k = 1; k <= N; k++) begin
        step(1'b0, 1'b1, '0, 1);
        if (k == N - 1) chk(out_valid == 1'b0, "R6", int'(out_valid), 0);
        if (k == N) chk(out_valid == 1'b1, "R6", int'(out_valid), 1);
      end
      drain();
    end

    // R7: full-rate stream, rank sweeping 0..7 (R4, R5 included)
    for (int c = 0; c < 2400; c++) begin
      step(1'b1, 1'b1, make_window(c / 8), c % 8);
      chk(in_ready == 1'b1, "R7", int'(in_ready), 1);
      if (c >= N) chk(out_valid == 1'b1, "R7", int'(out_valid), 1);
    end
    drain();

    // Fixed corner windows: all equal, extremes
    for (int r = 0; r < 8; r++) begin
      step(1'b1, 1'b1, {M{8'h5A}}, r);
      step(1'b1, 1'b1, {8'h00, 8'hFF, 8'h00, 8'hFF, 8'h80}, r);
      step(1'b1, 1'b1, {8'h01, 8'h02, 8'h03, 8'h04, 8'h05}, r);
    end
    drain();

    // R8 with R5: random stalls while ranks differ per window
    for (int c = 0; c < 4000; c++) begin
      int unsigned z = nxt();
      step(z[3:0] != 0, z[7:4] > 5, make_window(c), int'(z[18:16]));
    end
    for (int k = 0; k < 2 * N; k++) step(1'b0, 1'b1, '0, 1);
    chk(exp_q.size() == 0, "R8", exp_q.size(), 0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule